// File: doc/BRIEF.md
# Link Retry and Unsafe-Port Tracker

This block sits on the output side of a mesh router, next to the per-port transmit logic. Each output port keeps a sent packet until the downstream router acknowledges it. If no acknowledgement arrives within a programmable number of cycles, the block pulses a resend strobe for that port. It counts consecutive failed attempts. When that count goes past a programmable threshold, the port is declared permanently unsafe, and the route logic must choose another port.

The block also keeps a small congestion table with one penalty value per output port. The neighbouring router drives that value to reflect how full its input buffers are, and the block exposes it so that a port choice can take congestion into account. The block does not compute routes.

Top module: `link_retry_tracker`

## Requirements
- R1: After reset, every port is idle and safe: `busy`, `pkt_free`, `resend` and `unsafe_mask` are all zero, every penalty entry is zero, and the retry threshold is 3.
- R2: A `send_req` bit on a port that is idle and safe is accepted at a clock edge. From that edge the port shows `busy`=1, and it stays busy until the packet is acknowledged or the port is declared unsafe.
- R3: An `ack` bit on a busy port releases the packet. At the next edge `pkt_free` pulses for exactly one cycle and `busy` drops. The port's failure count clears, so the next packet gets the full number of resends.
- R4: If a busy port receives no ack, its `resend` bit pulses for one cycle `cfg_timeout` edges after the packet was accepted, and again every `cfg_timeout` edges after that. A `cfg_timeout` of 0 behaves like 1.
- R5: The failure count goes up by one at each expiry. The expiry that makes the count greater than the threshold produces no resend. Instead, it sets the port's `unsafe_mask` bit and clears `busy`. With threshold K, there are exactly K resend pulses before the port becomes unsafe.
- R6: An unsafe port stays unsafe until reset. While it is unsafe, `send_req` and `ack` on that port are ignored: `busy`, `pkt_free` and `resend` stay 0.
- R7: A write (`thr_wr_en`=1) loads `thr_wr_val` into the retry threshold at the clock edge. The new value applies to later expiries. A threshold of 0 makes the port unsafe on the first expiry.
- R8: When `nbr_pen_vld` is high for a port, that port's field of `nbr_pen` is stored into the same field of `pen_tbl` and appears there after the edge. Without the valid bit, the entry holds its value. Port p occupies bits [p*PEN_W +: PEN_W] of both buses.
- R9: Each port has its own timer, count and state. Activity on one port never changes another port's outputs.
- R10: If `ack` arrives in the same cycle as a timeout expiry, the ack wins: the packet is released and there is neither a resend nor a count increment.
- R11: `send_req` on a busy port does not restart its timer, and `ack` on an idle port produces no `pkt_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMO_W | Ack wait time in cycles |
| thr_wr_en | input | 1 | Write strobe for the retry threshold |
| thr_wr_val | input | CNT_W | New retry threshold value |
| send_req | input | N_PORTS | Start holding a new packet on a port |
| ack | input | N_PORTS | Acknowledgement from the downstream router |
| nbr_pen_vld | input | N_PORTS | Penalty update valid per port |
| nbr_pen | input | N_PORTS*PEN_W | Penalty values reported by neighbours |
| busy | output | N_PORTS | Port holds an unacknowledged packet |
| pkt_free | output | N_PORTS | One-cycle pulse: held packet may be deleted |
| resend | output | N_PORTS | One-cycle pulse: send the held packet again |
| unsafe_mask | output | N_PORTS | Port is permanently excluded from routing |
| pen_tbl | output | N_PORTS*PEN_W | Stored penalty per port |

## Verification
The checker watches several rules on every cycle:
- an unsafe bit never clears;
- an unsafe port is never busy, never resends and never releases;
- an ack on a busy port always produces a release on the next cycle, and a release never comes from an idle port;
- a penalty entry either holds or takes the neighbour's value, depending on the valid bit.

Some behaviour can only be shown by the bench scenarios. These are the exact spacing of resend pulses against the timeout, the number of resends before a port is declared unsafe for each threshold, the default threshold after reset, ack winning a tie with an expiry, and the count clearing after a successful ack.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    // Life cycle of one output port
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WAIT = 2'd1,
        PS_DEAD = 2'd2
    } port_state_e;

    localparam int unsigned DEFAULT_RETRIES = 3;

endpackage

// File: rtl/lrt_port_fsm.sv
module lrt_port_fsm
    import lrt_pkg::*;
#(
    parameter int unsigned TMO_W = 8,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic [CNT_W-1:0] thresh,
    input  logic             send_req,
    input  logic             ack,
    output logic             busy,
    output logic             unsafe,
    output logic             resend,
    output logic             pkt_free
);

    typedef struct packed {
        port_state_e      st;
        logic [TMO_W-1:0] tmr;
        logic [CNT_W-1:0] tries;
        logic             resend;
        logic             free;
    } fsm_t;

    fsm_t s_d, s_q;

    logic             expire;
    logic [CNT_W:0]   tries_nx;
    logic [TMO_W:0]   tmr_inc;

    always_comb begin
        s_d        = s_q;
        s_d.resend = 1'b0;
        s_d.free   = 1'b0;
        tmr_inc    = {1'b0, s_q.tmr} + {{TMO_W{1'b0}}, 1'b1};
        expire     = (tmr_inc >= {1'b0, cfg_timeout});
        tries_nx   = {1'b0, s_q.tries} + {{CNT_W{1'b0}}, 1'b1};
        unique case (s_q.st)
            PS_IDLE: begin
                if (send_req) begin
                    s_d.st    = PS_WAIT;
                    s_d.tmr   = '0;
                    s_d.tries = '0;
                end
            end
            PS_WAIT: begin
                if (ack) begin
                    s_d.st    = PS_IDLE;
                    s_d.free  = 1'b1;
                    s_d.tries = '0;
                    s_d.tmr   = '0;
                end else if (expire) begin
                    s_d.tmr = '0;
                    if (tries_nx > {1'b0, thresh}) begin
                        s_d.st = PS_DEAD;
                    end else begin
                        s_d.tries  = tries_nx[CNT_W-1:0];
                        s_d.resend = 1'b1;
                    end
                end else begin
                    s_d.tmr = tmr_inc[TMO_W-1:0];
                end
            end
            default: begin
                s_d.st = PS_DEAD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: PS_IDLE, tmr: '0, tries: '0, resend: 1'b0, free: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st == PS_WAIT);
    assign unsafe   = (s_q.st == PS_DEAD);
    assign resend   = s_q.resend;
    assign pkt_free = s_q.free;

endmodule

// File: rtl/lrt_thresh_reg.sv
module lrt_thresh_reg
    import lrt_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] thresh
);

    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(DEFAULT_RETRIES);

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } thr_t;

    thr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.val = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.val <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign thresh = r_q.val;

endmodule

// File: rtl/lrt_pen_table.sv
module lrt_pen_table #(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned PEN_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PORTS-1:0]       upd_vld,
    input  logic [N_PORTS*PEN_W-1:0] upd_val,
    output logic [N_PORTS*PEN_W-1:0] table_out
);

    typedef struct packed {
        logic [N_PORTS-1:0][PEN_W-1:0] ent;
    } pen_t;

    pen_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        for (int p = 0; p < N_PORTS; p++) begin
            if (upd_vld[p]) begin
                t_d.ent[p] = upd_val[p*PEN_W +: PEN_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign table_out = t_q.ent;

endmodule

// File: rtl/link_retry_tracker.sv
module link_retry_tracker
    import lrt_pkg::*;
#(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned TMO_W   = 8,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned PEN_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TMO_W-1:0]         cfg_timeout,
    input  logic                     thr_wr_en,
    input  logic [CNT_W-1:0]         thr_wr_val,
    input  logic [N_PORTS-1:0]       send_req,
    input  logic [N_PORTS-1:0]       ack,
    input  logic [N_PORTS-1:0]       nbr_pen_vld,
    input  logic [N_PORTS*PEN_W-1:0] nbr_pen,
    output logic [N_PORTS-1:0]       busy,
    output logic [N_PORTS-1:0]       pkt_free,
    output logic [N_PORTS-1:0]       resend,
    output logic [N_PORTS-1:0]       unsafe_mask,
    output logic [N_PORTS*PEN_W-1:0] pen_tbl
);

    logic [CNT_W-1:0] thresh;

    lrt_thresh_reg #(.CNT_W(CNT_W)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (thr_wr_en),
        .wr_val (thr_wr_val),
        .thresh (thresh)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        lrt_port_fsm #(.TMO_W(TMO_W), .CNT_W(CNT_W)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_timeout (cfg_timeout),
            .thresh      (thresh),
            .send_req    (send_req[p]),
            .ack         (ack[p]),
            .busy        (busy[p]),
            .unsafe      (unsafe_mask[p]),
            .resend      (resend[p]),
            .pkt_free    (pkt_free[p])
        );
    end

    lrt_pen_table #(.N_PORTS(N_PORTS), .PEN_W(PEN_W)) u_pen (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_vld   (nbr_pen_vld),
        .upd_val   (nbr_pen),
        .table_out (pen_tbl)
    );

endmodule

// File: rtl/link_retry_tracker_chk.sv
module link_retry_tracker_chk #(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned PEN_W   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_PORTS-1:0]       ack,
    input logic [N_PORTS-1:0]       nbr_pen_vld,
    input logic [N_PORTS*PEN_W-1:0] nbr_pen,
    input logic [N_PORTS-1:0]       busy,
    input logic [N_PORTS-1:0]       pkt_free,
    input logic [N_PORTS-1:0]       resend,
    input logic [N_PORTS-1:0]       unsafe_mask,
    input logic [N_PORTS*PEN_W-1:0] pen_tbl
);

    // R6: unsafe flags never clear outside reset
    assert_unsafe_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((unsafe_mask & $past(unsafe_mask)) == $past(unsafe_mask)));

    // R6: an unsafe port shows no activity
    assert_unsafe_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((unsafe_mask & (busy | resend | pkt_free)) == '0));

    // R5: a port only becomes unsafe while it was holding a packet
    assert_unsafe_from_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((unsafe_mask & ~$past(unsafe_mask) & ~$past(busy)) == '0));

    // R4: a resend strobe always leaves the packet held
    assert_resend_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((resend & ~busy) == '0));

    // R11: release only follows a held packet
    assert_free_from_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_free & ~$past(busy)) == '0));

    for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
        // R3: ack on a busy port frees it at the next edge
        assert_ack_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[p] && ack[p]) |=> (pkt_free[p] && !busy[p] && !resend[p]));

        // R8: entry loads on valid
        assert_pen_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            nbr_pen_vld[p] |=> (pen_tbl[p*PEN_W +: PEN_W] == $past(nbr_pen[p*PEN_W +: PEN_W])));

        // R8: entry holds without valid
        assert_pen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !nbr_pen_vld[p] |=> $stable(pen_tbl[p*PEN_W +: PEN_W]));
    end

endmodule

bind link_retry_tracker link_retry_tracker_chk #(.N_PORTS(N_PORTS), .PEN_W(PEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .nbr_pen_vld (nbr_pen_vld),
    .nbr_pen     (nbr_pen),
    .busy        (busy),
    .pkt_free    (pkt_free),
    .resend      (resend),
    .unsafe_mask (unsafe_mask),
    .pen_tbl     (pen_tbl)
);

// File: tb/link_retry_tracker_test.sv
module link_retry_tracker_test;

    localparam int NP = 4;
    localparam int TW = 8;
    localparam int CW = 4;
    localparam int PW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TW-1:0]   cfg_timeout = 8'd4;
    logic            thr_wr_en = 1'b0;
    logic [CW-1:0]   thr_wr_val = '0;
    logic [NP-1:0]   send_req = '0;
    logic [NP-1:0]   ack = '0;
    logic [NP-1:0]   nbr_pen_vld = '0;
    logic [NP*PW-1:0] nbr_pen = '0;
    logic [NP-1:0]   busy, pkt_free, resend, unsafe_mask;
    logic [NP*PW-1:0] pen_tbl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    link_retry_tracker #(.N_PORTS(NP), .TMO_W(TW), .CNT_W(CW), .PEN_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .thr_wr_en(thr_wr_en), .thr_wr_val(thr_wr_val),
        .send_req(send_req), .ack(ack), .nbr_pen_vld(nbr_pen_vld), .nbr_pen(nbr_pen),
        .busy(busy), .pkt_free(pkt_free), .resend(resend),
        .unsafe_mask(unsafe_mask), .pen_tbl(pen_tbl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        send_req = '0; ack = '0; nbr_pen_vld = '0; thr_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_thresh(input int v);
        thr_wr_en = 1'b1;
        thr_wr_val = CW'(v);
        @(negedge clk);
        thr_wr_en = 1'b0;
    endtask

    // Accept a packet on port p: edge E0 lies between this call and its return
    task automatic launch(input int p);
        send_req[p] = 1'b1;
        @(negedge clk);
        send_req[p] = 1'b0;
    endtask

    // fields: port, timeout, threshold (-1 = keep default), resends before ack (-1 = never),
    //         expected resends, expected unsafe
    localparam int NV = 8;
    localparam int VEC [NV][6] = '{
        '{0, 4, -1, -1, 3, 1},
        '{1, 5,  3,  1, 1, 0},
        '{2, 4,  1, -1, 1, 1},
        '{3, 6,  0, -1, 0, 1},
        '{0, 4,  2,  2, 2, 0},
        '{1, 4,  5,  0, 0, 0},
        '{2, 7,  2, -1, 2, 1},
        '{3, 1,  2, -1, 2, 1}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int p, tmo, thr, ack_after, exp_res, exp_uns;
        int nres, nfree, first_k, last_k, win;
        bit acked;

        // R1: reset state
        do_reset();
        check(busy == '0, "R1 busy", int'(busy), 0);
        check(pkt_free == '0 && resend == '0, "R1 strobes", int'({pkt_free, resend}), 0);
        check(unsafe_mask == '0, "R1 unsafe_mask", int'(unsafe_mask), 0);
        check(pen_tbl == '0, "R1 pen_tbl", int'(pen_tbl), 0);

        // Table-driven retry scenarios (R2, R3, R4, R5, R7)
        for (int v = 0; v < NV; v++) begin
            p = VEC[v][0]; tmo = VEC[v][1]; thr = VEC[v][2];
            ack_after = VEC[v][3]; exp_res = VEC[v][4]; exp_uns = VEC[v][5];
            do_reset();
            cfg_timeout = TW'(tmo);
            if (thr >= 0) set_thresh(thr);
            launch(p);
            check(busy[p] == 1'b1, "R2 busy after accept", int'(busy[p]), 1);
            nres = 0; nfree = 0; first_k = -1; last_k = 0; acked = 1'b0;
            win = (((thr < 0) ? 3 : thr) + 2) * tmo + 6;
            for (int k = 1; k <= win; k++) begin
                // k counts edges after acceptance; sample at the negedge following edge k
                if (ack_after >= 0 && !acked && nres == ack_after && k == last_k + 3) begin
                    ack[p] = 1'b1;
                    acked = 1'b1;
                end
                @(negedge clk);
                ack[p] = 1'b0;
                if (resend[p]) begin
                    nres++;
                    if (first_k < 0) first_k = k;
                    last_k = k;
                end
                if (pkt_free[p]) nfree++;
            end
            check(nres == exp_res, "R5 resend count", nres, exp_res);
            check(int'(unsafe_mask[p]) == exp_uns, "R5 unsafe flag", int'(unsafe_mask[p]), exp_uns);
            check(nfree == 1 - exp_uns, "R3 release count", nfree, 1 - exp_uns);
            check(busy[p] == 1'b0, "R3 busy cleared", int'(busy[p]), 0);
            if (exp_res > 0)
                check(first_k == tmo, "R4 first resend spacing", first_k, tmo);
        end

        // R4: resend pulses every timeout period, and timeout 0 acts like 1
        do_reset();
        cfg_timeout = 8'd5;
        launch(0);
        begin
            int ks[3];
            int c = 0;
            for (int k = 1; k <= 16; k++) begin
                @(negedge clk);
                if (resend[0] && c < 3) begin ks[c] = k; c++; end
            end
            check(c == 3 && ks[0] == 5 && ks[1] == 10 && ks[2] == 15, "R4 periodic resend",
                  ks[1], 10);
        end
        do_reset();
        cfg_timeout = 8'd0;
        launch(1);
        @(negedge clk);
        check(resend[1] == 1'b1, "R4 timeout zero", int'(resend[1]), 1);

        // R6 / R9: sticky unsafe, ignored requests, independent ports
        do_reset();
        cfg_timeout = 8'd4;
        set_thresh(0);
        launch(0);
        launch(1);
        repeat (6) @(negedge clk);
        check(unsafe_mask == 4'b0011, "R6 both dead", int'(unsafe_mask), 3);
        set_thresh(3);
        launch(2);
        send_req[0] = 1'b1;
        ack[0] = 1'b1;
        @(negedge clk);
        send_req[0] = 1'b0;
        ack[0] = 1'b0;
        check(busy[0] == 1'b0 && pkt_free[0] == 1'b0, "R6 dead port ignores requests",
              int'({busy[0], pkt_free[0]}), 0);
        check(busy[2] == 1'b1 && unsafe_mask[2] == 1'b0, "R9 other port unaffected",
              int'({busy[2], unsafe_mask[2]}), 2);
        repeat (30) @(negedge clk);
        check(unsafe_mask[0] == 1'b1, "R6 still unsafe", int'(unsafe_mask[0]), 1);
        do_reset();
        check(unsafe_mask == '0, "R6 reset clears", int'(unsafe_mask), 0);

        // R10: ack coinciding with expiry edge wins
        cfg_timeout = 8'd4;
        launch(3);
        repeat (3) @(negedge clk);   // edges 1..3 have passed
        ack[3] = 1'b1;                // registered at edge 4, the expiry edge
        @(negedge clk);
        ack[3] = 1'b0;
        check(pkt_free[3] == 1'b1 && resend[3] == 1'b0, "R10 ack beats expiry",
              int'({pkt_free[3], resend[3]}), 2);

        // R3: count cleared by ack -> next packet gets the full threshold again
        do_reset();
        cfg_timeout = 8'd4;
        set_thresh(1);
        launch(0);
        repeat (5) @(negedge clk);   // one resend done
        ack[0] = 1'b1;
        @(negedge clk);
        ack[0] = 1'b0;
        launch(0);
        begin
            int c = 0;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                if (resend[0]) c++;
            end
            check(c == 1 && unsafe_mask[0] == 1'b1, "R3 count cleared after ack", c, 1);
        end

        // R11: send_req while busy keeps timer; ack while idle is ignored
        do_reset();
        cfg_timeout = 8'd6;
        launch(1);
        repeat (2) @(negedge clk);
        launch(1);                   // edge 3
        repeat (2) @(negedge clk);   // edge 5
        check(resend[1] == 1'b0, "R11 no early resend", int'(resend[1]), 0);
        @(negedge clk);              // edge 6
        check(resend[1] == 1'b1, "R11 timer not restarted", int'(resend[1]), 1);
        ack[2] = 1'b1;
        @(negedge clk);
        ack[2] = 1'b0;
        check(pkt_free[2] == 1'b0, "R11 ack on idle port", int'(pkt_free[2]), 0);

        // R8: penalty table load and hold
        nbr_pen = 16'h0900;
        nbr_pen_vld = 4'b0100;
        @(negedge clk);
        nbr_pen_vld = '0;
        check(pen_tbl[8 +: 4] == 4'd9, "R8 load", int'(pen_tbl[8 +: 4]), 9);
        nbr_pen = 16'hF5FF;
        @(negedge clk);
        check(pen_tbl == 16'h0900, "R8 hold", int'(pen_tbl), 16'h0900);
        nbr_pen_vld = 4'b1001;
        @(negedge clk);
        nbr_pen_vld = '0;
        check(pen_tbl == 16'hF90F, "R8 multi-port load", int'(pen_tbl), 16'hF90F);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule